// File: doc/BRIEF.md
# Vector Segment Micro-op Splitter

This block accepts one decoded vector segment load/store instruction and breaks it into an ordered sequence of micro-ops. The sequence is issued one micro-op per output handshake. Each micro-op carries:

- its index;
- its destination register;
- the scalar base register;
- a second operand register, which is the stride register or the index vector register;
- a don't-care flag for each of the two operand registers.

The micro-op count and the operand assignment depend on the addressing mode. Unit-stride and strided instructions produce `emul × fields` micro-ops, all carrying the same scalar base and stride registers. Indexed instructions produce `max(lmul × fields, emul)` micro-ops. Only the first micro-op of an indexed instruction holds a meaningful base register. The index register group is walked only for the first `emul` micro-ops.

Splitting always starts at the first field's register group and advances one register per micro-op. A configuration that needs more micro-ops than the block supports, or that uses the reserved mode code, is refused: the block raises a one-cycle illegal pulse and issues nothing. A new instruction is taken only after the final micro-op of the current one has been handed off.

Top module: `seg_uop_splitter`

## Requirements
- R1: After reset `out_valid` and `illegal` are 0 and `in_ready` is 1.
- R2: For a legal instruction, micro-ops are issued with `out_idx` running 0, 1, 2, … up to count−1. The first one appears on the cycle after acceptance.
- R3: Unit-stride and strided modes (`in_mode` 0 and 1) issue `emul_regs × (in_nf_m1+1)` micro-ops. Every one of them carries `in_base` on `out_base` and `in_stride` on `out_ofs`, with both don't-care flags at 0.
- R4: In every mode, micro-op i targets `(in_vd + i) mod 32` on `out_vd`.
- R5: Indexed mode (`in_mode` 2) issues `max(lmul_regs × (in_nf_m1+1), emul_regs)` micro-ops.
- R6: In indexed mode, micro-op 0 carries `in_base` with `out_base_dc`=0. Every later micro-op has `out_base_dc`=1.
- R7: In indexed mode, micro-op i with i < emul_regs carries `(in_index + i) mod 32` on `out_ofs` with `out_ofs_dc`=0. For i ≥ emul_regs, `out_ofs_dc`=1.
- R8: Multiplier codes 0..3 mean 1, 2, 4 and 8 registers. Codes 4..7 are fractional and count as 1 register.
- R9: `out_last` is 1 exactly on the final micro-op. `in_ready` stays 0 while micro-ops are pending and returns to 1 on the cycle after the final handshake.
- R10: If `in_mode` is 3, or the computed count exceeds MAX_UOPS (8), `illegal` pulses for exactly one cycle after acceptance and `out_valid` stays 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, all micro-op outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| in_mode | input | 2 | 0 unit-stride, 1 strided, 2 indexed, 3 reserved |
| in_nf_m1 | input | 3 | Field count minus one |
| in_lmul | input | 3 | Data register multiplier code |
| in_emul | input | 3 | Effective (index/element) multiplier code |
| in_base | input | 5 | Scalar base register |
| in_stride | input | 5 | Scalar stride register |
| in_index | input | 5 | First index vector register |
| in_vd | input | 5 | First destination register |
| out_valid | output | 1 | Micro-op offered |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_idx | output | 3 | Micro-op index |
| out_vd | output | 5 | Destination register |
| out_base | output | 5 | Base register |
| out_base_dc | output | 1 | Base register is don't-care |
| out_ofs | output | 5 | Stride or index register |
| out_ofs_dc | output | 1 | Offset register is don't-care |
| out_last | output | 1 | Final micro-op of the instruction |
| illegal | output | 1 | One-cycle pulse: instruction refused |

## Verification
A corrupted index counter shows up on the very next handshake: `out_idx` skips or repeats, and `out_vd` and `out_ofs` move with it. A wrong stored count shows up as `out_last` on the wrong micro-op. It also shows up as `in_ready` returning too early or too late, visible within one cycle of the final handshake. A faulty multiplier decode or mode decode changes the length of the sequence, or flips the illegal/issue choice. These faults are seen on the first cycle after acceptance. Sweeping every mode, field count and multiplier code, with periodic back-pressure, exposes each of these faults at the ports.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [1:0] {
    MODE_UNIT    = 2'd0,
    MODE_STRIDED = 2'd1,
    MODE_INDEXED = 2'd2,
    MODE_RSVD    = 2'd3
  } seg_mode_e;

  typedef struct packed {
    seg_mode_e         mode;
    logic [2:0]        nf_m1;
    logic [2:0]        lmul;
    logic [2:0]        emul;
    logic [REG_AW-1:0] base;
    logic [REG_AW-1:0] stride;
    logic [REG_AW-1:0] index;
    logic [REG_AW-1:0] vd;
  } seg_instr_t;

  // Register-group size of a multiplier code; fractional codes occupy one register
  function automatic logic [3:0] mul_regs(input logic [2:0] code);
    logic [3:0] r;
    if (code[2]) r = 4'd1;
    else         r = 4'd1 << code[1:0];
    return r;
  endfunction
endpackage

// File: rtl/seg_uop_count.sv
module seg_uop_count
  import seg_split_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  seg_instr_t       instr,
  output logic [CNT_W-1:0] count,
  output logic [3:0]       emul_regs
);
  logic [3:0]       lmul_regs;
  logic [3:0]       fields;
  logic [CNT_W-1:0] data_groups;

  always_comb begin
    lmul_regs   = mul_regs(instr.lmul);
    emul_regs   = mul_regs(instr.emul);
    fields      = {1'b0, instr.nf_m1} + 4'd1;
    data_groups = CNT_W'(lmul_regs) * CNT_W'(fields);
    if (instr.mode == MODE_INDEXED) begin
      count = (data_groups > CNT_W'(emul_regs)) ? data_groups : CNT_W'(emul_regs);
    end else begin
      count = CNT_W'(emul_regs) * CNT_W'(fields);
    end
  end
endmodule

// File: rtl/seg_uop_fields.sv
module seg_uop_fields
  import seg_split_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  seg_instr_t        instr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [3:0]        emul_regs,
  output logic [REG_AW-1:0] vd,
  output logic [REG_AW-1:0] base,
  output logic              base_dc,
  output logic [REG_AW-1:0] ofs,
  output logic              ofs_dc
);
  always_comb begin
    vd   = instr.vd + REG_AW'(idx);
    base = instr.base;
    if (instr.mode == MODE_INDEXED) begin
      base_dc = (idx != '0);
      ofs     = instr.index + REG_AW'(idx);
      ofs_dc  = (32'(idx) >= 32'(emul_regs));
    end else begin
      base_dc = 1'b0;
      ofs     = instr.stride;
      ofs_dc  = 1'b0;
    end
  end
endmodule

// File: rtl/seg_uop_splitter.sv
module seg_uop_splitter
  import seg_split_pkg::*;
#(
  parameter int MAX_UOPS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [2:0]        in_nf_m1,
  input  logic [2:0]        in_lmul,
  input  logic [2:0]        in_emul,
  input  logic [REG_AW-1:0] in_base,
  input  logic [REG_AW-1:0] in_stride,
  input  logic [REG_AW-1:0] in_index,
  input  logic [REG_AW-1:0] in_vd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [$clog2(MAX_UOPS)-1:0] out_idx,
  output logic [REG_AW-1:0] out_vd,
  output logic [REG_AW-1:0] out_base,
  output logic              out_base_dc,
  output logic [REG_AW-1:0] out_ofs,
  output logic              out_ofs_dc,
  output logic              out_last,
  output logic              illegal
);
  localparam int IDX_W = $clog2(MAX_UOPS);
  localparam int CNT_W = 8;

  seg_instr_t       in_instr, instr_q, sel_instr;
  logic [IDX_W-1:0] sel_idx;
  logic [CNT_W-1:0] sel_count;
  logic [3:0]       sel_emul;
  logic [REG_AW-1:0] f_vd, f_base, f_ofs;
  logic             f_base_dc, f_ofs_dc, f_last;
  logic             accept, fire, legal;

  assign in_instr = '{mode: seg_mode_e'(in_mode), nf_m1: in_nf_m1, lmul: in_lmul,
                      emul: in_emul, base: in_base, stride: in_stride,
                      index: in_index, vd: in_vd};

  assign in_ready  = !out_valid;
  assign accept    = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign sel_instr = accept ? in_instr : instr_q;
  assign sel_idx   = accept ? '0 : out_idx + IDX_W'(1);

  seg_uop_count #(.CNT_W(CNT_W)) u_count (
    .instr     (sel_instr),
    .count     (sel_count),
    .emul_regs (sel_emul)
  );

  seg_uop_fields #(.IDX_W(IDX_W)) u_fields (
    .instr     (sel_instr),
    .idx       (sel_idx),
    .emul_regs (sel_emul),
    .vd        (f_vd),
    .base      (f_base),
    .base_dc   (f_base_dc),
    .ofs       (f_ofs),
    .ofs_dc    (f_ofs_dc)
  );

  assign legal  = (sel_instr.mode != MODE_RSVD) && (sel_count <= CNT_W'(MAX_UOPS));
  assign f_last = (CNT_W'(sel_idx) == sel_count - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q     <= '0;
      out_valid   <= 1'b0;
      out_idx     <= '0;
      out_vd      <= '0;
      out_base    <= '0;
      out_base_dc <= 1'b0;
      out_ofs     <= '0;
      out_ofs_dc  <= 1'b0;
      out_last    <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      illegal <= accept && !legal;
      if (accept) instr_q <= in_instr;
      if ((accept && legal) || (fire && !out_last)) begin
        out_valid   <= 1'b1;
        out_idx     <= sel_idx;
        out_vd      <= f_vd;
        out_base    <= f_base;
        out_base_dc <= f_base_dc;
        out_ofs     <= f_ofs;
        out_ofs_dc  <= f_ofs_dc;
        out_last    <= f_last;
      end else if (fire) begin
        out_valid <= 1'b0;
      end
    end
  end

  // Micro-op outputs hold while stalled
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_vd)
                                 && $stable(out_ofs) && $stable(out_last));

  // Index advances by one per non-final handshake
  p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_last |=> out_valid && out_idx == $past(out_idx) + IDX_W'(1));

  // Every sequence starts at index zero
  p_first_idx_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_idx == '0);

  // Final handshake releases the input side
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  // A refused instruction issues nothing and the pulse lasts one cycle
  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !out_valid ##1 !illegal);

  // Indexed base is only meaningful on micro-op 0
  p_base_dc_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && instr_q.mode == MODE_INDEXED |-> out_base_dc == (out_idx != '0));
endmodule

// File: tb/seg_uop_splitter_bench.sv
`timescale 1ns/1ps
module seg_uop_splitter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_mode = '0;
  logic [2:0] in_nf_m1 = '0, in_lmul = '0, in_emul = '0;
  logic [4:0] in_base = '0, in_stride = '0, in_index = '0, in_vd = '0;
  logic out_valid, out_ready = 1'b0;
  logic [2:0] out_idx;
  logic [4:0] out_vd, out_base, out_ofs;
  logic out_base_dc, out_ofs_dc, out_last, illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_uop_splitter u_seg_uop_splitter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_nf_m1(in_nf_m1), .in_lmul(in_lmul), .in_emul(in_emul),
    .in_base(in_base), .in_stride(in_stride), .in_index(in_index), .in_vd(in_vd),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_vd(out_vd),
    .out_base(out_base), .out_base_dc(out_base_dc), .out_ofs(out_ofs),
    .out_ofs_dc(out_ofs_dc), .out_last(out_last), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int regs_of(input int code);
    return (code >= 4) ? 1 : (1 << code);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);
    chk(illegal == 0, "R1 illegal", int'(illegal), 0);

    for (int cfg = 0; cfg < 2048; cfg++) begin
      int md, nf, lc, ec, lm, em, cnt, b, s, x, v;
      bit bad;
      md = cfg >> 9;
      nf = ((cfg >> 6) & 7) + 1;
      lc = (cfg >> 3) & 7;
      ec = cfg & 7;
      lm = regs_of(lc);   // R8: fractional codes count as one register
      em = regs_of(ec);
      if (md == 2) cnt = (lm * nf > em) ? lm * nf : em;  // R5
      else         cnt = em * nf;                        // R3
      bad = (md == 3) || (cnt > 8);
      b = cfg & 31;
      s = (cfg >> 1) & 31;
      x = (cfg * 7) & 31;
      v = (cfg * 3 + 27) & 31;

      chk(in_ready == 1, "R9 ready before accept", int'(in_ready), 1);
      in_mode = 2'(md); in_nf_m1 = 3'(nf - 1); in_lmul = 3'(lc); in_emul = 3'(ec);
      in_base = 5'(b); in_stride = 5'(s); in_index = 5'(x); in_vd = 5'(v);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;

      if (bad) begin
        chk(illegal == 1, "R10 illegal pulse", int'(illegal), 1);
        chk(out_valid == 0, "R10 no issue", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        chk(illegal == 0, "R10 pulse width", int'(illegal), 0);
        chk(out_valid == 0, "R10 still no issue", int'(out_valid), 0);
      end else begin
        for (int i = 0; i < cnt; i++) begin
          chk(out_valid == 1, "R2 valid", int'(out_valid), 1);
          chk(int'(out_idx) == i, "R2 idx", int'(out_idx), i);
          chk(int'(out_vd) == ((v + i) & 31), "R4 vd", int'(out_vd), (v + i) & 31);
          chk(out_last == (i == cnt - 1), "R9 last", int'(out_last), int'(i == cnt - 1));
          if (i > 0) chk(in_ready == 0, "R9 busy", int'(in_ready), 0);
          if (md == 2) begin
            chk(out_base_dc == (i != 0), "R6 base dc", int'(out_base_dc), int'(i != 0));
            if (i == 0) chk(int'(out_base) == b, "R6 base", int'(out_base), b);
            chk(out_ofs_dc == (i >= em), "R7 ofs dc", int'(out_ofs_dc), int'(i >= em));
            if (i < em) chk(int'(out_ofs) == ((x + i) & 31), "R7 ofs", int'(out_ofs), (x + i) & 31);
          end else begin
            chk(int'(out_base) == b && !out_base_dc, "R3 base", int'(out_base), b);
            chk(int'(out_ofs) == s && !out_ofs_dc, "R3 stride", int'(out_ofs), s);
          end
          if (((i + cfg) % 3) == 0) begin
            out_ready = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(out_valid == 1 && int'(out_idx) == i, "R11 hold idx", int'(out_idx), i);
            chk(int'(out_vd) == ((v + i) & 31), "R11 hold vd", int'(out_vd), (v + i) & 31);
          end
          out_ready = 1'b1;
          @(posedge clk);
          @(negedge clk);
          out_ready = 1'b0;
        end
        chk(out_valid == 0, "R9 drained", int'(out_valid), 0);
        chk(in_ready == 1, "R9 ready after last", int'(in_ready), 1);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule